// File: doc/BRIEF.md
# Preloadable Interval Timer

An interval timer with a 16-bit count that moves up by one on every cycle where a fixed-rate tick enable is high and the timer is in the run state. When a tick arrives while the count is at 0xFFFF, the count does not roll over to zero. It reloads a software-chosen preload value and raises an interrupt flag instead. The interval between flags is therefore 65536 minus the preload, counted in ticks. With a tick rate of 160,000 per second, a preload of 63936 gives 100 flags per second.

Software reaches the block through a byte-wide register bus. Writes take effect at the clock edge. Reads are combinational from the address. The bus exposes the following:

- The preload, which is committed as one 16-bit value when its low byte is written.
- The live count, which is read-only.
- A 2-bit control field that selects clear, stop or run.
- An interrupt byte that holds the pending flag, an enable bit and a 3-bit level.

The request output combines these interrupt fields.

Top module: `interval_timer`

## Requirements
- R1: After reset, the preload, the count, the control field and the interrupt byte all read 0, and `irq_req` is low.
- R2: A write to address 0 places the preload high byte in a holding register and leaves the visible preload unchanged. A write to address 1 commits {held high byte, written low byte} as the new preload. Addresses 0 and 1 read back the committed high and low bytes.
- R3: Address 2 returns bits 15:8 of the live count and address 3 returns bits 7:0. Writes to these addresses have no effect.
- R4: When the control is run (3), the count increases by one at every edge where `tick` is high and does not change at edges where `tick` is low.
- R5: When a tick arrives in run with the count at 0xFFFF, the count loads the preload and the pending flag sets at that same edge. Each later interval therefore lasts 65536 minus the preload ticks.
- R6: Control values 1 and 2 freeze the count at its present value. Returning to run resumes counting from that value.
- R7: Control value 0 forces the count to 0 and holds it there. After a start from 0, the first reload comes 65536 ticks later.
- R8: Address 5 is the interrupt byte. It reads as {pending, 3'b000, enable, level[2:0]}. A write there sets the enable from bit 3 and the level from bits 2:0, and bits 6:4 are ignored.
- R9: The pending flag sets on a reload whether or not the enable is set. Writing bit 7 as 1 clears it. Writing bit 7 as 0 leaves it unchanged.
- R10: `irq_req` is high exactly when the flag is pending, the enable is set and the level is nonzero. `irq_level` always shows the level field.
- R11: Address 4 reads the control field in bits 1:0, with the upper bits as 0. Writes set the field from bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable at the fixed tick rate |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Level field of the interrupt byte |

## Verification
A register write appears in the read data one clock edge after it is driven. A control change affects counting only from the edge after the one that stores it, so the tick that coincides with a stop or a clear write still advances the count. A reload becomes visible in the count, the pending flag and `irq_req` after the same edge that consumed the tick at 0xFFFF. The bench drives stimulus and samples on falling edges and keeps a free-running edge counter. Every expected count or interval is then an exact difference between recorded edge numbers: 65536 ticks for the first interval from 0, 65536 minus the preload for later ones, and doubled when ticks come every other cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam logic [2:0] ADR_PRE_HI = 3'd0;
    localparam logic [2:0] ADR_PRE_LO = 3'd1;
    localparam logic [2:0] ADR_CNT_HI = 3'd2;
    localparam logic [2:0] ADR_CNT_LO = 3'd3;
    localparam logic [2:0] ADR_CTL    = 3'd4;
    localparam logic [2:0] ADR_IRQ    = 3'd5;

    // Control field encodings; 2'd2 behaves like STOP
    typedef enum logic [1:0] {
        CTL_CLEAR = 2'd0,
        CTL_STOP  = 2'd1,
        CTL_HOLD  = 2'd2,
        CTL_RUN   = 2'd3
    } ctl_e;

    localparam int IRQ_PEND_BIT = 7;
    localparam int IRQ_EN_BIT   = 3;

endpackage

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [CNT_W-1:0] preload,
    output ctl_e             ctrl,
    output logic             irq_en,
    output logic [2:0]       irq_lvl,
    output logic             irq_ack
);
    localparam int HI_W = CNT_W - 8;

    typedef struct packed {
        logic [HI_W-1:0]  stage;
        logic [CNT_W-1:0] preload;
        ctl_e             ctrl;
        logic             en;
        logic [2:0]       lvl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (bus_addr)
                ADR_PRE_HI: r_d.stage   = bus_wdata[HI_W-1:0];
                ADR_PRE_LO: r_d.preload = {r_q.stage, bus_wdata};
                ADR_CTL:    r_d.ctrl    = ctl_e'(bus_wdata[1:0]);
                ADR_IRQ: begin
                    r_d.en  = bus_wdata[IRQ_EN_BIT];
                    r_d.lvl = bus_wdata[2:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{stage: '0, preload: '0, ctrl: CTL_CLEAR, en: 1'b0, lvl: 3'd0};
        end else begin
            r_q <= r_d;
        end
    end

    assign preload = r_q.preload;
    assign ctrl    = r_q.ctrl;
    assign irq_en  = r_q.en;
    assign irq_lvl = r_q.lvl;
    assign irq_ack = bus_we && (bus_addr == ADR_IRQ) && bus_wdata[IRQ_PEND_BIT];

endmodule

// File: rtl/timer_core.sv
module timer_core
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ctl_e             ctrl,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d  = c_q;
        wrap = 1'b0;
        case (ctrl)
            CTL_CLEAR: c_d.count = '0;
            CTL_RUN: begin
                if (tick) begin
                    if (c_q.count == TOP) begin
                        c_d.count = preload;
                        wrap      = 1'b1;
                    end else begin
                        c_d.count = c_q.count + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{count: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign count = c_q.count;

endmodule

// File: rtl/timer_irq.sv
module timer_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrap,
    input  logic       ack,
    input  logic       en,
    input  logic [2:0] lvl,
    output logic       pend,
    output logic       req
);
    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (ack)  i_d.pend = 1'b0;
        if (wrap) i_d.pend = 1'b1;   // a new reload wins over a same-cycle ack
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '{pend: 1'b0};
        end else begin
            i_q <= i_d;
        end
    end

    assign pend = i_q.pend;
    assign req  = i_q.pend && en && (lvl != 3'd0);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_we,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_req,
    output logic [2:0] irq_level
);
    logic [CNT_W-1:0] preload_w;
    logic [CNT_W-1:0] count_w;
    ctl_e             ctrl_w;
    logic             en_w;
    logic [2:0]       lvl_w;
    logic             ack_w;
    logic             wrap_w;
    logic             pend_w;

    timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .preload   (preload_w),
        .ctrl      (ctrl_w),
        .irq_en    (en_w),
        .irq_lvl   (lvl_w),
        .irq_ack   (ack_w)
    );

    timer_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ctrl    (ctrl_w),
        .preload (preload_w),
        .count   (count_w),
        .wrap    (wrap_w)
    );

    timer_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (wrap_w),
        .ack   (ack_w),
        .en    (en_w),
        .lvl   (lvl_w),
        .pend  (pend_w),
        .req   (irq_req)
    );

    always_comb begin
        case (bus_addr)
            ADR_PRE_HI: bus_rdata = 8'(preload_w >> 8);
            ADR_PRE_LO: bus_rdata = preload_w[7:0];
            ADR_CNT_HI: bus_rdata = 8'(count_w >> 8);
            ADR_CNT_LO: bus_rdata = count_w[7:0];
            ADR_CTL:    bus_rdata = {6'b0, ctrl_w};
            ADR_IRQ:    bus_rdata = {pend_w, 3'b000, en_w, lvl_w};
            default:    bus_rdata = 8'h00;
        endcase
    end

    assign irq_level = lvl_w;

endmodule

// File: rtl/timer_chk.sv
module timer_chk
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input ctl_e             ctrl,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] preload,
    input logic             wrap,
    input logic             pend,
    input logic             ack,
    input logic             irq_req,
    input logic             irq_en,
    input logic [2:0]       irq_lvl
);
    localparam logic [CNT_W-1:0] TOP = '1;

    AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == CTL_RUN && tick && count != TOP) |=> count == $past(count) + 1'b1); // R4

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == CTL_RUN && !tick) |=> $stable(count)); // R4

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == CTL_RUN && tick && count == TOP) |=> (count == $past(preload) && pend)); // R5

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == CTL_STOP || ctrl == CTL_HOLD) |=> $stable(count)); // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == CTL_CLEAR) |=> count == '0); // R7

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> !pend); // R9

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend); // R9

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend && irq_en && irq_lvl != 3'd0)); // R10

endmodule

bind interval_timer timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ctrl    (ctrl_w),
    .count   (count_w),
    .preload (preload_w),
    .wrap    (wrap_w),
    .pend    (pend_w),
    .ack     (ack_w),
    .irq_req (irq_req),
    .irq_en  (en_w),
    .irq_lvl (lvl_w)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_lvl = 1'b1;
    logic       tick_alt = 1'b0;
    logic       phase = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic       tick;
    logic [7:0] rdata;
    logic       irq_req;
    logic [2:0] irq_level;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int wr_cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) phase <= ~phase;
    assign tick = tick_alt ? phase : tick_lvl;

    interval_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        wr_cyc = cyc;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(3'd2, h);
        rd(3'd3, l);
        v = {h, l};
    endtask

    task automatic wait_irq(output int t);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_req && n < 100000);
        t = cyc;
        if (!irq_req) chk("R5 interrupt never raised", 0, 1);
        wr(3'd5, 8'h89);
    endtask

    always @(posedge clk) begin
        if (cyc > 180000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=180000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        int s, t0, t1, t2;
        logic [15:0] pre_list [5];
        pre_list[0] = 16'hFFF8; pre_list[1] = 16'hFFF0; pre_list[2] = 16'hFF00;
        pre_list[3] = 16'hF000; pre_list[4] = 16'hFFF0;

        // R1 reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), b);
            chk($sformatf("R1 reset read addr %0d", a), b, 8'h00);
        end
        chk("R1 reset irq_req", irq_req, 0);
        rst_n = 1'b1;

        // R2 preload staging and commit
        wr(3'd0, 8'h12);
        rd(3'd0, b); chk("R2 preload hi before commit", b, 8'h00);
        rd(3'd1, b); chk("R2 preload lo before commit", b, 8'h00);
        wr(3'd1, 8'h34);
        rd(3'd0, b); chk("R2 preload hi after commit", b, 8'h12);
        rd(3'd1, b); chk("R2 preload lo after commit", b, 8'h34);

        // R3 count is read-only
        wr(3'd2, 8'hAA); wr(3'd3, 8'h55);
        rd16(v); chk("R3 count unaffected by writes", v, 16'h0000);

        // R11 control readback
        wr(3'd4, 8'hFD);
        rd(3'd4, b); chk("R11 control readback", b, 8'h01);
        wr(3'd4, 8'h00);
        rd(3'd4, b); chk("R11 control cleared", b, 8'h00);

        // R8 interrupt byte fields
        wr(3'd5, 8'h0D);
        rd(3'd5, b); chk("R8 irq byte readback", b, 8'h0D);
        chk("R10 irq_level shows level", irq_level, 3'd5);
        chk("R10 no request without pending", irq_req, 0);
        wr(3'd5, 8'h70);
        rd(3'd5, b); chk("R8 bits 6:4 ignored", b, 8'h00);

        // R7 + R5: first interval from zero, then reload of FFFC
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFC);
        wr(3'd4, 8'h03);
        s = wr_cyc;
        while (cyc < s + 65535) @(negedge clk);
        rd16(v); chk("R7 count before first reload", v, 16'hFFFF);
        rd(3'd5, b); chk("R9 not pending before reload", b, 8'h00);
        @(negedge clk);
        rd16(v); chk("R7 reload after 65536 ticks", v, 16'hFFFC);
        rd(3'd5, b); chk("R9 pending with enable off", b, 8'h80);
        chk("R10 no request while disabled", irq_req, 0);

        // R6 stop: the tick at the storing edge still counts
        wr(3'd4, 8'h01);
        rd16(v); chk("R6 stop value", v, 16'hFFFE);
        repeat (5) @(negedge clk);
        rd16(v); chk("R6 frozen while stopped", v, 16'hFFFE);

        // R9/R10 gating with the timer frozen
        wr(3'd5, 8'h08);
        chk("R10 level zero blocks request", irq_req, 0);
        rd(3'd5, b); chk("R9 pending kept by bit7=0", b, 8'h88);
        wr(3'd5, 8'h0B);
        chk("R10 request raised", irq_req, 1);
        chk("R10 irq_level value", irq_level, 3'd3);
        wr(3'd5, 8'h83);
        rd(3'd5, b); chk("R9 write 1 acknowledges", b, 8'h03);
        chk("R10 request drops after ack", irq_req, 0);
        wr(3'd5, 8'h89);

        // R6 resume from held value
        wr(3'd4, 8'h03);
        rd16(v); chk("R6 resume starts at held value", v, 16'hFFFE);
        @(negedge clk);
        rd16(v); chk("R6 resume continues", v, 16'hFFFF);
        wait_irq(t0);

        // R5 interval sweep; last entry uses a tick every other cycle
        for (int k = 0; k < 5; k++) begin
            wr(3'd4, 8'h01);
            wr(3'd5, 8'h89);
            wr(3'd0, pre_list[k][15:8]);
            wr(3'd1, pre_list[k][7:0]);
            if (k == 4) tick_alt = 1'b1;
            wr(3'd4, 8'h03);
            wait_irq(t0);
            wait_irq(t1);
            wait_irq(t2);
            chk($sformatf("R5 interval A preload %0h", pre_list[k]), t1 - t0,
                (65536 - pre_list[k]) * (k == 4 ? 2 : 1));
            chk($sformatf("R5 interval B preload %0h", pre_list[k]), t2 - t1,
                (65536 - pre_list[k]) * (k == 4 ? 2 : 1));
        end
        tick_alt = 1'b0;

        // R7 clear forces zero while ticking
        wr(3'd4, 8'h00);
        repeat (4) @(negedge clk);
        rd16(v); chk("R7 clear holds zero", v, 16'h0000);

        // R4 no advance without tick, then exact advance
        tick_lvl = 1'b0;
        wr(3'd4, 8'h03);
        repeat (5) @(negedge clk);
        rd16(v); chk("R4 no tick no count", v, 16'h0000);
        tick_lvl = 1'b1;
        repeat (7) @(negedge clk);
        rd16(v); chk("R4 count equals ticks", v, 16'h0007);

        // R6 code 2 also freezes
        wr(3'd4, 8'h02);
        repeat (4) @(negedge clk);
        rd16(v); chk("R6 code 2 freezes", v, 16'h0009);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule